// File: doc/BRIEF.md
# Pipeline interlock hazard controller

This unit decides, cycle by cycle, which stages of a four-stage instruction pipeline (fetch, decode, operand access, execute) may advance and where an empty slot must be inserted. It carries a small descriptor for each in-flight instruction: a tag plus five attribute flags saying whether it reads data memory, writes data memory, carries a long immediate word, writes an address register or uses an address register to form an address. From the descriptors in the stage registers it detects three kinds of conflict and resolves each by delaying the younger instruction while the older one keeps moving.

The first conflict is on the data-memory port: a write occupies it for two cycles, its operand-access cycle and its execute cycle. The second is on the program-memory port: a long immediate needs a second fetch. The third is a coarse address-register dependency: any pending address-register write blocks any later instruction that forms an address from a register, until the writer has left execute. The unit also counts the cycles lost to these delays. A fetch source offers one descriptor per cycle and treats it as taken on any clock edge where `hold_if` was low.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every stage is empty. `ex_valid`, all hold and bubble outputs, and `stall_count` are 0.
- R2: With no conflicts, a descriptor taken at clock edge t is reported on `ex_valid`/`ex_tag` after edge t+3, for exactly one cycle. Back-to-back descriptors complete one per cycle.
- R3: When the operand-access stage holds a memory read or write and the execute stage holds a memory write, `hold_op` is 1 (with `hold_id` and `hold_if`) and `bubble_ex` is 1 for that cycle. The memory access proceeds one cycle later.
- R4: A descriptor with the long-immediate flag stays in fetch for exactly one extra cycle after it is taken. In that cycle `hold_if` and `bubble_id` are 1 and no new descriptor is taken.
- R5: A descriptor in decode that uses an address register is held there, with `bubble_op` = 1, in every cycle in which the operand-access or execute stage holds a valid address-register writer.
- R6: A hold on a stage also holds every earlier stage, and the held stages keep their contents. In each cycle at most one bubble is inserted, into the stage just after the latest held stage.
- R7: No delay occurs when the younger instruction does not use the contended resource. Examples are a write followed by an instruction with no memory access, and an address-register write followed by an instruction that uses no address register.
- R8: `stall_count` rises by exactly one for each cycle in which any bubble is inserted, and stays unchanged otherwise.
- R9: Every taken descriptor reaches execute exactly once, in the order taken, with its tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offered descriptor is a real instruction |
| in_tag | input | TAG_W | Tag of the offered descriptor |
| in_mem_rd | input | 1 | Offered instruction reads data memory |
| in_mem_wr | input | 1 | Offered instruction writes data memory (two port cycles) |
| in_long_imm | input | 1 | Offered instruction needs a second program-memory fetch |
| in_ar_wr | input | 1 | Offered instruction writes an address register |
| in_ar_use | input | 1 | Offered instruction forms an address from an address register |
| hold_if | output | 1 | Fetch stage frozen; the offered descriptor is not taken |
| hold_id | output | 1 | Decode stage frozen |
| hold_op | output | 1 | Operand-access stage frozen |
| bubble_id | output | 1 | Empty slot enters decode this edge |
| bubble_op | output | 1 | Empty slot enters operand access this edge |
| bubble_ex | output | 1 | Empty slot enters execute this edge |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_tag | output | TAG_W | Tag of the instruction in execute |
| stall_count | output | CNT_W | Number of cycles in which a bubble was inserted |

## Verification
The bench builds the block with an 8-bit tag and a 16-bit stall counter. The narrow tag wraps several times over the few thousand random descriptors, so ordering across the wrap point is checked. The counter stays far from its limit, so every increment is compared exactly. Directed pairs isolate each conflict and each harmless near-miss. The random stream then layers a long-immediate fetch under a downstream memory or address-register hold, which is where the latest held stage must win.

// File: rtl/pilk_pkg.sv
package pilk_pkg;

    localparam int NSTG = 4;

    typedef enum logic [1:0] {
        STG_IF = 2'd0,
        STG_ID = 2'd1,
        STG_OP = 2'd2,
        STG_EX = 2'd3
    } stage_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic long_imm;
        logic ar_wr;
        logic ar_use;
    } op_attr_t;

    // younger touches the data port while older is in its second write cycle
    function automatic logic port_clash(op_attr_t younger, op_attr_t older);
        return (younger.mem_rd | younger.mem_wr) & older.mem_wr;
    endfunction

    // younger forms an address while older has an address-register write in flight
    function automatic logic areg_blocks(op_attr_t younger, op_attr_t older);
        return younger.ar_use & older.ar_wr;
    endfunction

endpackage

// File: rtl/pilk_stage_reg.sv
module pilk_stage_reg
    import pilk_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             bubble,
    input  logic             mark_x,
    input  logic             src_valid,
    input  logic [TAG_W-1:0] src_tag,
    input  op_attr_t         src_attr,
    output logic             q_valid,
    output logic [TAG_W-1:0] q_tag,
    output op_attr_t         q_attr,
    output logic             q_xdone
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_attr  <= '0;
            q_xdone <= 1'b0;
        end else if (hold) begin
            if (mark_x) begin
                q_xdone <= 1'b1;
            end
        end else if (bubble) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_attr  <= '0;
            q_xdone <= 1'b0;
        end else begin
            q_valid <= src_valid;
            q_tag   <= src_tag;
            q_attr  <= src_valid ? src_attr : '0;
            q_xdone <= 1'b0;
        end
    end

endmodule

// File: rtl/pilk_hazard.sv
module pilk_hazard
    import pilk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic     [NSTG-1:0] v,
    input  op_attr_t [NSTG-1:0] a,
    input  logic                if_xdone,
    output logic     [NSTG-1:0] stall_req
);

    localparam int IF_I = int'(STG_IF);
    localparam int ID_I = int'(STG_ID);
    localparam int OP_I = int'(STG_OP);
    localparam int EX_I = int'(STG_EX);

    logic mem_hit;
    logic areg_hit;
    logic xfetch_hit;

    always_comb begin
        mem_hit = v[OP_I] & v[EX_I] & port_clash(a[OP_I], a[EX_I]);

        areg_hit = 1'b0;
        for (int j = ID_I + 1; j < NSTG; j++) begin
            areg_hit = areg_hit | (v[ID_I] & v[j] & areg_blocks(a[ID_I], a[j]));
        end

        xfetch_hit = v[IF_I] & a[IF_I].long_imm & ~if_xdone;
    end

    always_comb begin
        stall_req       = '0;
        stall_req[OP_I] = mem_hit;
        stall_req[ID_I] = areg_hit;
        stall_req[IF_I] = xfetch_hit;
    end

    logic unused_attr_bits;
    assign unused_attr_bits = ^a;

    // R3: a read or write in operand access never meets a second write cycle without a request
    a_r3_port_request: assert property (@(posedge clk) disable iff (rst)
        (v[OP_I] && v[EX_I] && a[EX_I].mem_wr && (a[OP_I].mem_rd || a[OP_I].mem_wr)) |-> stall_req[OP_I]);

    // R7: an instruction with no memory access never raises a port request
    a_r7_no_false_port: assert property (@(posedge clk) disable iff (rst)
        (!a[OP_I].mem_rd && !a[OP_I].mem_wr) |-> !stall_req[OP_I]);

endmodule

// File: rtl/pilk_stall_resolve.sv
module pilk_stall_resolve #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stall_req,
    output logic [N-1:0] hold,
    output logic [N-1:0] bubble
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign hold[i] = |stall_req[N-1:i];
        if (i == 0) begin : g_first
            assign bubble[i] = 1'b0;
        end else begin : g_rest
            assign bubble[i] = stall_req[i-1] & ~(|stall_req[N-1:i]);
        end
    end

    // R6: at most one empty slot per cycle
    a_r6_one_bubble: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bubble));

    // R6: a request anywhere always produces exactly one bubble
    a_r6_bubble_for_stall: assert property (@(posedge clk) disable iff (rst)
        (|stall_req) |-> ($countones(bubble) == 1));

endmodule

// File: rtl/pilk_perf_cnt.sv
module pilk_perf_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
    import pilk_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_mem_rd,
    input  logic             in_mem_wr,
    input  logic             in_long_imm,
    input  logic             in_ar_wr,
    input  logic             in_ar_use,
    output logic             hold_if,
    output logic             hold_id,
    output logic             hold_op,
    output logic             bubble_id,
    output logic             bubble_op,
    output logic             bubble_ex,
    output logic             ex_valid,
    output logic [TAG_W-1:0] ex_tag,
    output logic [CNT_W-1:0] stall_count
);

    localparam int IF_I = int'(STG_IF);
    localparam int ID_I = int'(STG_ID);
    localparam int OP_I = int'(STG_OP);
    localparam int EX_I = int'(STG_EX);

    logic     [NSTG-1:0]            stg_v;
    logic     [NSTG-1:0][TAG_W-1:0] stg_t;
    op_attr_t [NSTG-1:0]            stg_a;
    logic     [NSTG-1:0]            stg_x;
    logic     [NSTG-1:0]            stall_req;
    logic     [NSTG-1:0]            hold;
    logic     [NSTG-1:0]            bubble;
    op_attr_t                       in_attr;

    always_comb begin
        in_attr.mem_rd   = in_mem_rd;
        in_attr.mem_wr   = in_mem_wr;
        in_attr.long_imm = in_long_imm;
        in_attr.ar_wr    = in_ar_wr;
        in_attr.ar_use   = in_ar_use;
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        logic             src_v;
        logic [TAG_W-1:0] src_t;
        op_attr_t         src_a;
        logic             mark;

        if (s == 0) begin : g_head
            assign src_v = in_valid;
            assign src_t = in_tag;
            assign src_a = in_attr;
            assign mark  = stall_req[IF_I];
        end else begin : g_body
            assign src_v = stg_v[s-1];
            assign src_t = stg_t[s-1];
            assign src_a = stg_a[s-1];
            assign mark  = 1'b0;
        end

        pilk_stage_reg #(.TAG_W(TAG_W)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .hold     (hold[s]),
            .bubble   (bubble[s]),
            .mark_x   (mark),
            .src_valid(src_v),
            .src_tag  (src_t),
            .src_attr (src_a),
            .q_valid  (stg_v[s]),
            .q_tag    (stg_t[s]),
            .q_attr   (stg_a[s]),
            .q_xdone  (stg_x[s])
        );
    end

    pilk_hazard u_hazard (
        .clk      (clk),
        .rst      (rst),
        .v        (stg_v),
        .a        (stg_a),
        .if_xdone (stg_x[IF_I]),
        .stall_req(stall_req)
    );

    pilk_stall_resolve #(.N(NSTG)) u_resolve (
        .clk      (clk),
        .rst      (rst),
        .stall_req(stall_req),
        .hold     (hold),
        .bubble   (bubble)
    );

    pilk_perf_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (|bubble),
        .count(stall_count)
    );

    assign hold_if   = hold[IF_I];
    assign hold_id   = hold[ID_I];
    assign hold_op   = hold[OP_I];
    assign bubble_id = bubble[ID_I];
    assign bubble_op = bubble[OP_I];
    assign bubble_ex = bubble[EX_I];
    assign ex_valid  = stg_v[EX_I];
    assign ex_tag    = stg_t[EX_I];

    logic unused_misc;
    assign unused_misc = ^{hold[EX_I], bubble[IF_I], stg_x[NSTG-1:1], stg_a[EX_I]};

    // R3: the younger memory access waits and an empty slot follows the writer
    a_r3_port_hold: assert property (@(posedge clk) disable iff (rst)
        (stg_v[OP_I] && stg_v[EX_I] && stg_a[EX_I].mem_wr &&
         (stg_a[OP_I].mem_rd || stg_a[OP_I].mem_wr)) |-> (hold_op && bubble_ex));

    // R5: an address user in decode stays put while any writer is ahead
    a_r5_areg_hold: assert property (@(posedge clk) disable iff (rst)
        (stg_v[ID_I] && stg_a[ID_I].ar_use &&
         ((stg_v[OP_I] && stg_a[OP_I].ar_wr) || (stg_v[EX_I] && stg_a[EX_I].ar_wr)))
        |-> (hold_id && !bubble_id));

    // R4: the extra program fetch takes exactly one cycle
    a_r4_xfetch_once: assert property (@(posedge clk) disable iff (rst)
        stall_req[IF_I] |=> !stall_req[IF_I]);

    // R6: a frozen decode stage keeps its instruction
    a_r6_freeze_id: assert property (@(posedge clk) disable iff (rst)
        hold_id |=> ($stable(stg_t[ID_I]) && $stable(stg_v[ID_I])));

    // R8: the counter steps once per bubble cycle
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (|stall_req) |=> (stall_count == $past(stall_count) + CNT_W'(1)));

    // R8: no bubble, no change
    a_r8_count_idle: assert property (@(posedge clk) disable iff (rst)
        !(|stall_req) |=> $stable(stall_count));

endmodule

// File: tb/tb_pipe_interlock_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_interlock_ctrl;

    localparam int TAG_W = 8;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid, in_mem_rd, in_mem_wr, in_long_imm, in_ar_wr, in_ar_use;
    logic [TAG_W-1:0] in_tag;
    logic             hold_if, hold_id, hold_op, bubble_id, bubble_op, bubble_ex, ex_valid;
    logic [TAG_W-1:0] ex_tag;
    logic [CNT_W-1:0] stall_count;

    always #2 clk = ~clk;

    pipe_interlock_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_mem_rd(in_mem_rd), .in_mem_wr(in_mem_wr), .in_long_imm(in_long_imm),
        .in_ar_wr(in_ar_wr), .in_ar_use(in_ar_use),
        .hold_if(hold_if), .hold_id(hold_id), .hold_op(hold_op),
        .bubble_id(bubble_id), .bubble_op(bubble_op), .bubble_ex(bubble_ex),
        .ex_valid(ex_valid), .ex_tag(ex_tag), .stall_count(stall_count)
    );

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] t;
        logic             rd, wr, li, aw, au, xd;
    } bd_t;

    bd_t m [4];
    int  n_chk = 0;
    int  n_err = 0;
    int  m_cnt = 0;
    int  ret_next = 0;
    int  tag_next = 0;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // latest stage that must wait, -1 when none (R3, R4, R5, R6)
    function automatic int model_h();
        bit c_mem, c_ar, c_x;
        c_mem = m[2].v && (m[2].rd || m[2].wr) && m[3].v && m[3].wr;
        c_ar  = m[1].v && m[1].au && ((m[2].v && m[2].aw) || (m[3].v && m[3].aw));
        c_x   = m[0].v && m[0].li && !m[0].xd;
        if (c_mem) return 2;
        if (c_ar)  return 1;
        if (c_x)   return 0;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m[i] = '0;
        m_cnt = 0;
    endtask

    task automatic model_step();
        int  h;
        bd_t nin;
        h = model_h();
        nin = '0;
        nin.v = in_valid; nin.t = in_tag;
        nin.rd = in_valid & in_mem_rd; nin.wr = in_valid & in_mem_wr;
        nin.li = in_valid & in_long_imm; nin.aw = in_valid & in_ar_wr;
        nin.au = in_valid & in_ar_use;
        if (h >= 0) m_cnt++;
        m[3] = (h == 2) ? bd_t'(0) : m[2];
        if (h < 2) m[2] = (h == 1) ? bd_t'(0) : m[1];
        if (h < 1) m[1] = (h == 0) ? bd_t'(0) : m[0];
        if (h >= 0) begin
            if (m[0].li) m[0].xd = 1'b1;
        end else begin
            m[0] = nin;
        end
    endtask

    task automatic compare_all();
        int h;
        h = model_h();
        chk("R4", "hold_if",   int'(hold_if),   int'(h >= 0));
        chk("R5", "hold_id",   int'(hold_id),   int'(h >= 1));
        chk("R3", "hold_op",   int'(hold_op),   int'(h >= 2));
        chk("R6", "bubble_id", int'(bubble_id), int'(h == 0));
        chk("R6", "bubble_op", int'(bubble_op), int'(h == 1));
        chk("R6", "bubble_ex", int'(bubble_ex), int'(h == 2));
        chk("R2", "ex_valid",  int'(ex_valid),  int'(m[3].v));
        chk("R8", "stall_count", int'(stall_count), m_cnt % (1 << CNT_W));
        if (m[3].v) begin
            chk("R9", "retire tag", int'(ex_tag), ret_next % (1 << TAG_W));
            ret_next++;
        end
    endtask

    task automatic cycle(input logic v, input logic rd, input logic wr, input logic li,
                         input logic aw, input logic au, output bit taken);
        @(negedge clk);
        in_valid = v; in_tag = TAG_W'(tag_next);
        in_mem_rd = rd; in_mem_wr = wr; in_long_imm = li; in_ar_wr = aw; in_ar_use = au;
        compare_all();
        taken = v && (model_h() < 0);
        @(posedge clk);
        model_step();
        if (taken) tag_next++;
    endtask

    task automatic issue(input logic rd, input logic wr, input logic li,
                         input logic aw, input logic au);
        bit taken;
        taken = 1'b0;
        while (!taken) cycle(1'b1, rd, wr, li, aw, au, taken);
    endtask

    task automatic idle(input int n);
        bit taken;
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, taken);
    endtask

    task automatic expect_loss(input string req, input string what, input int base, input int exp);
        @(negedge clk);
        chk(req, what, int'(stall_count) - base, exp);
    endtask

    initial begin
        int base;
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        in_valid = 0; in_tag = '0; in_mem_rd = 0; in_mem_wr = 0;
        in_long_imm = 0; in_ar_wr = 0; in_ar_use = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ex_valid in reset", int'(ex_valid), 0);
        chk("R1", "holds in reset", int'({hold_if, hold_id, hold_op}), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "ex_valid after reset", int'(ex_valid), 0);
        chk("R1", "bubbles after reset", int'({bubble_id, bubble_op, bubble_ex}), 0);
        chk("R1", "stall_count after reset", int'(stall_count), 0);

        // R2: plain stream, no delay
        base = int'(stall_count);
        for (int i = 0; i < 6; i++) issue(0, 0, 0, 0, 0);
        idle(6);
        expect_loss("R2", "plain stream bubbles", base, 0);

        // R3: write then read
        base = int'(stall_count);
        issue(0, 1, 0, 0, 0); issue(1, 0, 0, 0, 0); idle(6);
        expect_loss("R3", "write-read bubbles", base, 1);
        // R3: write then write
        base = int'(stall_count);
        issue(0, 1, 0, 0, 0); issue(0, 1, 0, 0, 0); idle(6);
        expect_loss("R3", "write-write bubbles", base, 1);
        // R7: write then no memory access
        base = int'(stall_count);
        issue(0, 1, 0, 0, 0); issue(0, 0, 0, 0, 0); idle(6);
        expect_loss("R7", "write-plain bubbles", base, 0);

        // R4: single and back-to-back long immediates
        base = int'(stall_count);
        issue(0, 0, 1, 0, 0); idle(6);
        expect_loss("R4", "one long immediate", base, 1);
        base = int'(stall_count);
        issue(0, 0, 1, 0, 0); issue(0, 0, 1, 0, 0); idle(6);
        expect_loss("R4", "two long immediates", base, 2);

        // R5: dependent user right behind and one slot behind the writer
        base = int'(stall_count);
        issue(0, 0, 0, 1, 0); issue(0, 0, 0, 0, 1); idle(6);
        expect_loss("R5", "adjacent address dependency", base, 2);
        base = int'(stall_count);
        issue(0, 0, 0, 1, 0); issue(0, 0, 0, 0, 0); issue(0, 0, 0, 0, 1); idle(6);
        expect_loss("R5", "gap-one address dependency", base, 1);
        // R7: writer followed by non-user, user with no writer
        base = int'(stall_count);
        issue(0, 0, 0, 1, 0); issue(0, 0, 0, 0, 0); idle(6);
        issue(0, 0, 0, 0, 1); idle(6);
        expect_loss("R7", "no address dependency", base, 0);

        // R6: long immediate fetch beneath a memory hold
        base = int'(stall_count);
        issue(0, 1, 0, 0, 0); issue(1, 0, 0, 0, 0); issue(0, 0, 1, 0, 0); idle(6);
        expect_loss("R6", "overlapped holds", base, 2);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            bit taken;
            if (($urandom % 10) == 0) begin
                cycle(1'b0, 0, 0, 0, 0, 0, taken);
            end else begin
                issue(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
                      ($urandom % 5) == 0, ($urandom % 3) == 0);
            end
        end
        idle(8);
        @(negedge clk);
        chk("R9", "all taken retired", ret_next, tag_next);
        summary();
    end

endmodule